// File: doc/BRIEF.md
# Display Read Burst Request Planner

This block sits in front of the bus master of a display-layer read channel and decides, one request at a time, when a read may begin and what shape it takes. A start pulse hands it a word-aligned base address and a word count. From then on it watches the free space of the downstream pixel FIFO, which is counted in 32-bit words. Once enough room has opened up, it offers a request that carries an AHB HBURST code, a beat count and a start address. The offer is held on a valid/accept handshake until the bus engine takes it.

Two configuration inputs shape each request. A 2-bit size select sets the preferred burst, which fixes both the free-space threshold that triggers a request and the largest burst type that may be used. A defined-length-only flag forbids undefined-length bursts. Under that flag, any 2- or 3-word remnant is split into single transfers. No burst ever runs across a 1 KB address boundary.

The control is a three-state machine:
- `ST_IDLE` has no transfer pending. A start pulse with a non-zero count takes it to `ST_WAIT_ROOM`.
- `ST_WAIT_ROOM` holds a transfer and waits for FIFO room. A start pulse reloads the transfer, and moves to `ST_IDLE` if its count is zero. Room at or above the threshold moves to `ST_OFFER` and captures the burst decision.
- `ST_OFFER` drives the request. On accept it returns to `ST_WAIT_ROOM`, or to `ST_IDLE` when that burst was the last of the transfer.

Top module: `burst_req_planner`

## Requirements
- R1: After reset `req_valid_o` is low, and it stays low until a start pulse with a non-zero count has been taken.
- R2: The free-space threshold is 1, 4, 8 or 16 words for size select 0, 1, 2 or 3. A request is raised only if `fifo_free_i` was at or above the threshold for the current select in a cycle spent in `ST_WAIT_ROOM`. `req_valid_o` rises on the following clock edge.
- R3: With size select 1 no burst is longer than 4 beats. With select 2 no burst is longer than 8 beats. Selects 0 and 3 allow up to 16 beats.
- R4: The burst chosen is the largest allowed type that fits the smallest of three counts: free FIFO words, remaining words, and words left before the next 1 KB boundary. Codes and beats are SINGLE=3'b000 with 1 beat, INCR=3'b001 with 2 or 3 beats, INCR4=3'b011 with 4, INCR8=3'b101 with 8, and INCR16=3'b111 with 16.
- R5: With the defined-length-only flag low, a fit of 2 or 3 words is issued as INCR (3'b001) with exactly that many beats.
- R6: With the defined-length-only flag high, INCR is never issued. A fit of 2 or 3 words is issued as single transfers, one request at a time.
- R7: While `req_valid_o` is high and `req_accept_i` is low, the address, code and beat count hold their values. `req_valid_o` stays high.
- R8: In an accept cycle the address advances by 4 × beats and the remaining count drops by the beats. `req_valid_o` is low in the next cycle. No request is made once the remaining count reaches zero.
- R9: A start pulse loads a new base address and count in `ST_IDLE` or `ST_WAIT_ROOM`. A start with a count of zero leaves no request. A start pulse while a request is offered is ignored.
- R10: Changes to the size select or the flag while a request is offered do not alter that request. They apply to the next decision only.
- R11: The last word of every burst lies in the same 1 KB block as its first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Pulse that loads a new transfer |
| base_addr_i | input | ADDR_W | Word-aligned byte address of the transfer |
| word_cnt_i | input | CNT_W | Number of 32-bit words in the transfer |
| fifo_free_i | input | FREE_W | Free space of the pixel FIFO in words |
| blen_sel_i | input | 2 | Preferred burst size select (0..3) |
| defined_only_i | input | 1 | Forbid undefined-length INCR bursts |
| req_accept_i | input | 1 | Bus engine takes the offered request |
| req_valid_o | output | 1 | A request is offered |
| req_hburst_o | output | 3 | HBURST code of the request |
| req_beats_o | output | 5 | Beat count of the request (1..16) |
| req_addr_o | output | ADDR_W | Start byte address of the request |

## Verification
Three events can collide in one cycle. The first is a start pulse landing in the same cycle as an accept. The second is a change of size select or flag while a request is offered and not yet taken. The third is a free-space level crossing the threshold just as a new transfer is loaded. The bench holds accept low while an offer is up, then pulses start with another address and flips both configuration fields. It expects the offer unchanged and the transfer carried on from the old address. A long random phase fires start, accept, configuration and free-space changes independently, so such collisions happen often. A behavioural model, which processes a start before checking room and ignores start while offering, settles every cycle and is compared with the outputs on each falling edge.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [2:0] {
        HB_SINGLE = 3'b000,
        HB_INCR   = 3'b001,
        HB_INCR4  = 3'b011,
        HB_INCR8  = 3'b101,
        HB_INCR16 = 3'b111
    } hburst_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_ROOM = 2'd1,
        ST_OFFER     = 2'd2
    } plan_state_e;

    typedef struct packed {
        hburst_e    code;
        logic [4:0] beats;
    } burst_t;

    // Free words needed before a read may start (R2)
    function automatic logic [4:0] trigger_words(input logic [1:0] sel);
        case (sel)
            2'd0:    return 5'd1;
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            default: return 5'd16;
        endcase
    endfunction

    // Longest burst the select allows (R3)
    function automatic logic [4:0] size_cap(input logic [1:0] sel);
        case (sel)
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            default: return 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/bp_room_gate.sv
module bp_room_gate
    import bp_pkg::*;
#(
    parameter int FREE_W = 8
) (
    input  logic [FREE_W-1:0] fifo_free_i,
    input  logic [1:0]        blen_sel_i,
    output logic              room_ok_o
);
    // Threshold compare against the configured preferred size (R2)
    assign room_ok_o = (fifo_free_i >= FREE_W'(trigger_words(blen_sel_i)));
endmodule

// File: rtl/bp_span_limit.sv
module bp_span_limit #(
    parameter int FREE_W = 8,
    parameter int CNT_W  = 16,
    parameter int OFF_W  = 8
) (
    input  logic [FREE_W-1:0] fifo_free_i,
    input  logic [CNT_W-1:0]  remain_i,
    input  logic [OFF_W-1:0]  word_off_i,
    output logic [4:0]        span_o
);
    localparam int BOUND_WORDS = 1 << OFF_W;

    logic [OFF_W:0] to_bound;
    logic [4:0]     free_s;
    logic [4:0]     rem_s;
    logic [4:0]     bnd_s;
    logic [4:0]     min_a;

    // Words left before the next boundary (R11)
    assign to_bound = (OFF_W+1)'(BOUND_WORDS) - {1'b0, word_off_i};

    // Each operand is saturated to 16, the longest burst
    assign free_s = (fifo_free_i >= FREE_W'(16)) ? 5'd16 : fifo_free_i[4:0];
    assign rem_s  = (remain_i >= CNT_W'(16))     ? 5'd16 : remain_i[4:0];
    assign bnd_s  = (to_bound >= (OFF_W+1)'(16)) ? 5'd16 : to_bound[4:0];

    assign min_a  = (free_s < rem_s) ? free_s : rem_s;
    assign span_o = (min_a < bnd_s) ? min_a : bnd_s;
endmodule

// File: rtl/bp_burst_pick.sv
module bp_burst_pick
    import bp_pkg::*;
(
    input  logic [4:0] span_i,
    input  logic [1:0] blen_sel_i,
    input  logic       defined_only_i,
    output burst_t     burst_o
);
    logic [4:0] cap;
    logic [4:0] fit;

    assign cap = size_cap(blen_sel_i);
    assign fit = (span_i < cap) ? span_i : cap;

    // Largest allowed type that fits (R4); remnants per R5 / R6
    always_comb begin
        if (fit >= 5'd16) begin
            burst_o = '{code: HB_INCR16, beats: 5'd16};
        end else if (fit >= 5'd8) begin
            burst_o = '{code: HB_INCR8, beats: 5'd8};
        end else if (fit >= 5'd4) begin
            burst_o = '{code: HB_INCR4, beats: 5'd4};
        end else if ((fit >= 5'd2) && !defined_only_i) begin
            burst_o = '{code: HB_INCR, beats: fit};
        end else begin
            burst_o = '{code: HB_SINGLE, beats: 5'd1};
        end
    end
endmodule

// File: rtl/bp_xfer_track.sv
module bp_xfer_track #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [CNT_W-1:0]  word_cnt_i,
    input  logic              advance_i,
    input  logic [4:0]        beats_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CNT_W-1:0]  remain_o
);
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  rem_q;

    // Load on start, step forward on accept (R8, R9)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else if (load_i) begin
            addr_q <= base_addr_i;
            rem_q  <= word_cnt_i;
        end else if (advance_i) begin
            addr_q <= addr_q + ADDR_W'({beats_i, 2'b00});
            rem_q  <= rem_q - CNT_W'(beats_i);
        end
    end

    assign addr_o   = addr_q;
    assign remain_o = rem_q;
endmodule

// File: rtl/burst_req_planner.sv
module burst_req_planner
    import bp_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 16,
    parameter int FREE_W      = 8,
    parameter int BOUND_BYTES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [CNT_W-1:0]  word_cnt_i,
    input  logic [FREE_W-1:0] fifo_free_i,
    input  logic [1:0]        blen_sel_i,
    input  logic              defined_only_i,
    input  logic              req_accept_i,
    output logic              req_valid_o,
    output logic [2:0]        req_hburst_o,
    output logic [4:0]        req_beats_o,
    output logic [ADDR_W-1:0] req_addr_o
);
    localparam int BOUND_WORDS = BOUND_BYTES / 4;
    localparam int OFF_W       = $clog2(BOUND_WORDS);

    plan_state_e       state_q, state_d;
    burst_t            burst_q;
    burst_t            pick;
    logic              room_ok;
    logic [4:0]        span;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  remain;
    logic              load_en;
    logic              advance_en;
    logic              last_burst;
    logic              cnt_nonzero;

    // Start is honoured outside ST_OFFER only (R9)
    assign load_en     = start_i && (state_q != ST_OFFER);
    assign advance_en  = (state_q == ST_OFFER) && req_accept_i;
    assign last_burst  = (remain == CNT_W'(burst_q.beats));
    assign cnt_nonzero = (word_cnt_i != '0);

    bp_room_gate #(.FREE_W(FREE_W)) u_gate (
        .fifo_free_i (fifo_free_i),
        .blen_sel_i  (blen_sel_i),
        .room_ok_o   (room_ok)
    );

    bp_span_limit #(.FREE_W(FREE_W), .CNT_W(CNT_W), .OFF_W(OFF_W)) u_span (
        .fifo_free_i (fifo_free_i),
        .remain_i    (remain),
        .word_off_i  (cur_addr[OFF_W+1:2]),
        .span_o      (span)
    );

    bp_burst_pick u_pick (
        .span_i         (span),
        .blen_sel_i     (blen_sel_i),
        .defined_only_i (defined_only_i),
        .burst_o        (pick)
    );

    bp_xfer_track #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_en),
        .base_addr_i (base_addr_i),
        .word_cnt_i  (word_cnt_i),
        .advance_i   (advance_en),
        .beats_i     (burst_q.beats),
        .addr_o      (cur_addr),
        .remain_o    (remain)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i && cnt_nonzero) begin
                    state_d = ST_WAIT_ROOM;
                end
            end
            ST_WAIT_ROOM: begin
                if (start_i) begin
                    state_d = cnt_nonzero ? ST_WAIT_ROOM : ST_IDLE;
                end else if (room_ok) begin
                    state_d = ST_OFFER;
                end
            end
            ST_OFFER: begin
                if (req_accept_i) begin
                    state_d = last_burst ? ST_IDLE : ST_WAIT_ROOM;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output register: the decision is frozen on entry to ST_OFFER (R7, R10)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_q <= '{code: HB_SINGLE, beats: 5'd0};
        end else if ((state_q == ST_WAIT_ROOM) && (state_d == ST_OFFER)) begin
            burst_q <= pick;
        end
    end

    assign req_valid_o  = (state_q == ST_OFFER);
    assign req_hburst_o = burst_q.code;
    assign req_beats_o  = burst_q.beats;
    assign req_addr_o   = cur_addr;
endmodule

// File: rtl/bp_plan_chk.sv
module bp_plan_chk #(
    parameter int OFF_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       blen_sel_i,
    input logic             defined_only_i,
    input logic             req_valid_o,
    input logic             req_accept_i,
    input logic [2:0]       req_hburst_o,
    input logic [4:0]       req_beats_o,
    input logic [OFF_W-1:0] word_off
);
    localparam int BOUND_WORDS = 1 << OFF_W;

    // R7
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && !req_accept_i |=> req_valid_o && $stable(word_off)
            && $stable(req_hburst_o) && $stable(req_beats_o));

    // R8
    drop_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && req_accept_i |=> !req_valid_o);

    // R4
    code_beats_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |->
            (req_hburst_o == 3'b000 && req_beats_o == 5'd1) ||
            (req_hburst_o == 3'b001 && (req_beats_o == 5'd2 || req_beats_o == 5'd3)) ||
            (req_hburst_o == 3'b011 && req_beats_o == 5'd4) ||
            (req_hburst_o == 3'b101 && req_beats_o == 5'd8) ||
            (req_hburst_o == 3'b111 && req_beats_o == 5'd16));

    // R11
    no_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |->
            ((OFF_W+1)'(word_off) + (OFF_W+1)'(req_beats_o)) <= (OFF_W+1)'(BOUND_WORDS));

    // R3
    size_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid_o) |->
            (($past(blen_sel_i) != 2'd1) || (req_beats_o <= 5'd4)) &&
            (($past(blen_sel_i) != 2'd2) || (req_beats_o <= 5'd8)));

    // R6
    defined_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid_o) && $past(defined_only_i) |-> req_hburst_o != 3'b001);
endmodule

bind burst_req_planner bp_plan_chk #(.OFF_W(OFF_W)) u_plan_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .blen_sel_i     (blen_sel_i),
    .defined_only_i (defined_only_i),
    .req_valid_o    (req_valid_o),
    .req_accept_i   (req_accept_i),
    .req_hburst_o   (req_hburst_o),
    .req_beats_o    (req_beats_o),
    .word_off       (req_addr_o[OFF_W+1:2])
);

// File: tb/test_burst_req_planner.sv
module test_burst_req_planner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_addr_i = '0;
    logic [15:0] word_cnt_i = '0;
    logic [7:0]  fifo_free_i = '0;
    logic [1:0]  blen_sel_i = '0;
    logic        defined_only_i = 1'b0;
    logic        req_accept_i = 1'b0;
    logic        req_valid_o;
    logic [2:0]  req_hburst_o;
    logic [4:0]  req_beats_o;
    logic [31:0] req_addr_o;

    burst_req_planner i_burst_req_planner (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
        .word_cnt_i(word_cnt_i), .fifo_free_i(fifo_free_i), .blen_sel_i(blen_sel_i),
        .defined_only_i(defined_only_i), .req_accept_i(req_accept_i),
        .req_valid_o(req_valid_o), .req_hburst_o(req_hburst_o),
        .req_beats_o(req_beats_o), .req_addr_o(req_addr_o)
    );

    always #10 clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    acc_mode = 0;
    int    cyc = 0;
    bit    finished = 0;
    string tag = "R1";

    // Behavioural reference state
    bit          m_busy = 0;
    bit          m_valid = 0;
    logic [31:0] m_addr = '0;
    int          m_rem = 0;
    int          m_code = 0;
    int          m_beats = 0;

    function automatic int thr(int sel);
        if (sel == 0) return 1;
        if (sel == 1) return 4;
        if (sel == 2) return 8;
        return 16;
    endfunction

    task automatic choose(input int free, input int rem, input logic [31:0] a,
                          input int sel, input bit dlo, output int code, output int beats);
        int lim;
        int cap;
        lim = free;
        if (rem < lim) lim = rem;
        if (256 - int'(a[9:2]) < lim) lim = 256 - int'(a[9:2]);
        cap = (sel == 1) ? 4 : (sel == 2) ? 8 : 16;
        if (cap < lim) lim = cap;
        if (lim >= 16)              begin code = 7; beats = 16; end
        else if (lim >= 8)          begin code = 5; beats = 8;  end
        else if (lim >= 4)          begin code = 3; beats = 4;  end
        else if (lim >= 2 && !dlo)  begin code = 1; beats = lim; end
        else                        begin code = 0; beats = 1;  end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_valid = 0; m_rem = 0;
        end else if (m_valid) begin
            if (req_accept_i) begin
                m_addr  = m_addr + 32'(4 * m_beats);
                m_rem   = m_rem - m_beats;
                m_valid = 0;
                m_busy  = (m_rem > 0);
            end
        end else if (start_i) begin
            m_addr = base_addr_i;
            m_rem  = int'(word_cnt_i);
            m_busy = (word_cnt_i != 0);
        end else if (m_busy && int'(fifo_free_i) >= thr(int'(blen_sel_i))) begin
            choose(int'(fifo_free_i), m_rem, m_addr, int'(blen_sel_i), defined_only_i,
                   m_code, m_beats);
            m_valid = 1;
        end
    end

    task automatic chk(input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n && !finished) begin
            chk("valid", req_valid_o, m_valid);
            if (m_valid && req_valid_o) begin
                chk("hburst", req_hburst_o, m_code);
                chk("beats", req_beats_o, m_beats);
                chk("addr", req_addr_o, m_addr);
            end
        end
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk);
            start_i = 0;
            if (acc_mode == 0) req_accept_i = 1;
            else if (acc_mode == 1) req_accept_i = ($urandom_range(0, 1) == 1);
            else req_accept_i = 0;
        end
    endtask

    task automatic go(input logic [31:0] a, input int cnt);
        @(negedge clk);
        start_i = 1; base_addr_i = a; word_cnt_i = 16'(cnt);
        tick(1);
    endtask

    task automatic drain();
        int k = 0;
        while ((m_busy || m_valid) && k < 3000) begin
            tick(1);
            k++;
        end
    endtask

    task automatic setup(input int sel, input bit dlo, input int free);
        blen_sel_i = 2'(sel); defined_only_i = dlo; fifo_free_i = 8'(free);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        chk("reset valid", req_valid_o, 0);
        rst_n = 1;
        setup(0, 0, 20);
        tick(5);
        chk("no request before start", req_valid_o, 0);

        tag = "R4";   // 16, 16, 8
        acc_mode = 0; setup(0, 0, 20);
        go(32'h1000, 40); drain();

        tag = "R5";   // 4, 4, INCR 3
        setup(1, 0, 40);
        go(32'h3000, 11); drain();

        tag = "R3";   // 8, 8, 8, 4, INCR 2
        setup(2, 0, 40);
        go(32'h4000, 30); drain();

        tag = "R6";   // 4, then singles
        setup(1, 1, 40);
        go(32'h5000, 7); drain();
        setup(0, 1, 40);
        go(32'h5400, 19); drain();

        tag = "R11";  // INCR 2 up to the boundary, then 16, then INCR 2
        setup(3, 0, 32);
        go(32'h13F8, 20); drain();

        tag = "R2";
        setup(2, 0, 7);
        go(32'h6000, 8);
        tick(10);
        chk("below threshold sel2", req_valid_o, 0);
        fifo_free_i = 8;
        tick(1);
        chk("at threshold sel2", req_valid_o, 1);
        drain();
        setup(3, 0, 15);
        go(32'h6800, 16);
        tick(8);
        chk("below threshold sel3", req_valid_o, 0);
        fifo_free_i = 16;
        drain();

        tag = "R9";
        go(32'h7000, 0);
        tick(5);
        chk("zero count start", req_valid_o, 0);

        tag = "R10";
        acc_mode = 2; setup(0, 0, 20);
        go(32'h8000, 40);
        tick(3);
        chk("offer up", req_valid_o, 1);
        @(negedge clk);
        start_i = 1; base_addr_i = 32'h9000; word_cnt_i = 5;
        blen_sel_i = 1; defined_only_i = 1;
        tick(3);
        chk("addr kept R9", req_addr_o, 32'h8000);
        chk("beats kept R10", req_beats_o, 16);
        acc_mode = 0; setup(0, 0, 20);
        drain();

        tag = "R7";
        acc_mode = 1; setup(0, 0, 24);
        go(32'h0A3C0, 50); drain();

        tag = "R8";
        for (int c = 0; c < 6000; c++) begin
            @(negedge clk);
            start_i = 0;
            req_accept_i = ($urandom_range(0, 2) != 0);
            fifo_free_i = 8'($urandom_range(0, 40));
            if ($urandom_range(0, 19) == 0) begin
                blen_sel_i = 2'($urandom_range(0, 3));
                defined_only_i = ($urandom_range(0, 2) == 0);
            end
            if ((!m_busy && !m_valid && $urandom_range(0, 3) == 0) ||
                $urandom_range(0, 59) == 0) begin
                start_i = 1;
                base_addr_i = ($urandom_range(0, 1) == 1) ?
                              (32'h0002_0000 | 32'($urandom_range(0, 255) * 4)) :
                              ($urandom & 32'hFFFF_FFFC);
                word_cnt_i = 16'($urandom_range(0, 60));
            end
        end
        acc_mode = 0; setup(0, 0, 20);
        drain();
        tick(2);
        chk("idle after last burst", req_valid_o, 0);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule